// File: doc/BRIEF.md
# Pi/4-Shifted Differential Phase Encoder

This block takes a serial bit stream, qualified by a per-bit valid strobe, and groups consecutive accepted bits into pairs. Each pair selects a phase step that is an odd multiple of pi/4. The step is added to a running phase held as a modulo-8 index in pi/4 units. Because every step is odd, consecutive symbols alternate between two QPSK constellations that sit pi/4 apart.

The encoder publishes the phase index with a one-cycle symbol strobe. It can also publish signed fixed-point I/Q coordinates, taken from an eight-entry table computed from parameters. A synchronous clear returns the phase to the reference value. An active-low reset does the same. Pulse shaping and everything downstream belong to the consumer.

Top module: `dqpsk_phase_enc`

## Requirements
- R1: After reset the outputs are as follows: `phaseIdx` is 0, `symValid` is 0, `iOut` is +1.0 (2^(SAMPLE_W-2)) and `qOut` is 0.
- R2: Accepted bits are counted from 1 after reset or clear. An odd-numbered bit is the first member X of a pair, and the next accepted bit is Y. `symValid` is high for exactly the one cycle after the clock edge that accepts Y, so there is one strobe per two accepted bits.
- R3: For pairs with X=0, the phase step is +1 (pi/4) when Y=0 and +3 (3pi/4) when Y=1.
- R4: For pairs with X=1, the phase step is -1 (-pi/4) when Y=0 and -3 (-3pi/4) when Y=1.
- R5: `phaseIdx` wraps modulo 8 in both directions.
- R6: Cycles with `bitValid` low change nothing. A waiting X bit is held across any number of such cycles.
- R7: `clearIn` sets `phaseIdx` to 0 on the next edge and discards any waiting X bit. A bit offered in the same cycle as `clearIn` is dropped. No strobe follows a clear.
- R8: `iOut`/`qOut` equal round(2^(SAMPLE_W-2)·cos) and round(2^(SAMPLE_W-2)·sin) of `phaseIdx`·pi/4. They track `phaseIdx` in the same cycle, so each takes one of five levels.
- R9: Every symbol flips bit 0 of `phaseIdx`, so consecutive symbols alternate between the even and odd constellations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearIn | input | 1 | Synchronous phase and pairing clear |
| bitValid | input | 1 | `bitIn` is accepted this cycle |
| bitIn | input | 1 | Serial data bit |
| phaseIdx | output | 3 | Current phase in pi/4 units |
| symValid | output | 1 | One-cycle strobe for a new symbol |
| iOut | output | SAMPLE_W | In-phase coordinate, signed |
| qOut | output | SAMPLE_W | Quadrature coordinate, signed |

## Verification
The assertions assume that inputs are stable and known at each rising edge. They also assume that `clearIn` is an ordinary data-path input that may coincide with a valid bit. The bench drives every input on the falling edge, so nothing changes near the sampling edge. It deliberately overlaps `clearIn` with valid bits and with waiting X bits. Long idle gaps and random valid patterns cover the pairing rule under irregular arrival.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;
  localparam int PHASE_W = 3;

  typedef struct packed {
    logic clear;   // return phase to reference
    logic step;    // apply one dibit step this edge
    logic xBit;    // first member of the pair
    logic yBit;    // second member of the pair
  } ctrlStrobes_t;

  function automatic logic [PHASE_W-1:0] stepOf(input logic x, input logic y);
    case ({x, y})
      2'b00:   stepOf = 3'd1;
      2'b01:   stepOf = 3'd3;
      2'b10:   stepOf = 3'd7;
      default: stepOf = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/dqpsk_ctrl.sv
module dqpsk_ctrl
  import dqpsk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clearIn,
  input  logic         bitValid,
  input  logic         bitIn,
  output ctrlStrobes_t strobes
);
  logic pending;
  logic heldX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      heldX   <= 1'b0;
    end else if (clearIn) begin
      pending <= 1'b0;
    end else if (bitValid) begin
      pending <= ~pending;
      if (!pending) heldX <= bitIn;
    end
  end

  always_comb begin
    strobes.clear = clearIn;
    strobes.step  = bitValid & pending & ~clearIn;
    strobes.xBit  = heldX;
    strobes.yBit  = bitIn;
  end

  // R2
  pair_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> !strobes.step);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !clearIn) |=> ($stable(pending) && $stable(heldX)));
endmodule

// File: rtl/dqpsk_datapath.sv
module dqpsk_datapath
  import dqpsk_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter bit USE_IQ   = 1'b1
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  output logic [PHASE_W-1:0]         phaseIdx,
  output logic                       symValid,
  output logic signed [SAMPLE_W-1:0] iOut,
  output logic signed [SAMPLE_W-1:0] qOut
);
  localparam int UNIT = 1 << (SAMPLE_W - 2);
  localparam int DIAG = (UNIT * 181 + 128) / 256;
  localparam logic signed [SAMPLE_W-1:0] P1 = SAMPLE_W'(UNIT);
  localparam logic signed [SAMPLE_W-1:0] PD = SAMPLE_W'(DIAG);

  logic [PHASE_W-1:0] phaseQ;
  logic               symQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
      symQ   <= 1'b0;
    end else if (strobes.clear) begin
      phaseQ <= '0;
      symQ   <= 1'b0;
    end else begin
      symQ <= strobes.step;
      if (strobes.step) phaseQ <= phaseQ + stepOf(strobes.xBit, strobes.yBit);
    end
  end

  assign phaseIdx = phaseQ;
  assign symValid = symQ;

  generate
    if (USE_IQ) begin : g_iq
      always_comb begin
        case (phaseQ)
          3'd0: begin iOut =  P1; qOut =  '0; end
          3'd1: begin iOut =  PD; qOut =  PD; end
          3'd2: begin iOut =  '0; qOut =  P1; end
          3'd3: begin iOut = -PD; qOut =  PD; end
          3'd4: begin iOut = -P1; qOut =  '0; end
          3'd5: begin iOut = -PD; qOut = -PD; end
          3'd6: begin iOut =  '0; qOut = -P1; end
          default: begin iOut = PD; qOut = -PD; end
        endcase
      end
    end else begin : g_noiq
      assign iOut = '0;
      assign qOut = '0;
    end
  endgenerate

  // R9
  parity_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step) |=> (phaseQ[0] != $past(phaseQ[0])));

  // R7
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (phaseQ == '0 && !symQ));

  // R2
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    symQ |-> $past(strobes.step));

  // R8
  axis_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    USE_IQ |-> ((iOut == '0 || qOut == '0) == !phaseQ[0]));
endmodule

// File: rtl/dqpsk_phase_enc.sv
module dqpsk_phase_enc
  import dqpsk_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter bit USE_IQ   = 1'b1
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clearIn,
  input  logic                       bitValid,
  input  logic                       bitIn,
  output logic [2:0]                 phaseIdx,
  output logic                       symValid,
  output logic signed [SAMPLE_W-1:0] iOut,
  output logic signed [SAMPLE_W-1:0] qOut
);
  ctrlStrobes_t strobes;

  dqpsk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clearIn(clearIn),
    .bitValid(bitValid), .bitIn(bitIn), .strobes(strobes)
  );

  dqpsk_datapath #(.SAMPLE_W(SAMPLE_W), .USE_IQ(USE_IQ)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .phaseIdx(phaseIdx), .symValid(symValid), .iOut(iOut), .qOut(qOut)
  );
endmodule

// File: tb/sim_dqpsk_phase_enc.sv
module sim_dqpsk_phase_enc;
  localparam int W = 12;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearIn = 1'b0, bitValid = 1'b0, bitIn = 1'b0;
  logic [2:0] phaseIdx;
  logic symValid;
  logic signed [W-1:0] iOut, qOut;

  dqpsk_phase_enc #(.SAMPLE_W(W), .USE_IQ(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .bitValid(bitValid),
    .bitIn(bitIn), .phaseIdx(phaseIdx), .symValid(symValid),
    .iOut(iOut), .qOut(qOut)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int mPhase = 0, mPend = 0, mX = 0, mSym = 0, lastSymPhase = -1;
  string tag = "R1";
  bit done = 0;

  function automatic int levelOf(int p, bit useSin);
    real a, v;
    a = p * PI / 4.0;
    v = useSin ? $sin(a) : $cos(a);
    return int'($floor(v * real'(1 << (W - 2)) + 0.5));
  endfunction

  function automatic int incOf(int x, int y);
    if (x == 0) return (y == 0) ? 1 : 3;
    return (y == 0) ? -1 : -3;
  endfunction

  task automatic compare();
    checks++;
    if (phaseIdx !== 3'(mPhase) || symValid !== mSym[0]) begin
      fails++;
      $display("FAIL %s phase/sym actual %0d/%0b expected %0d/%0d", tag, phaseIdx, symValid, mPhase, mSym);
    end
    checks++;
    if (int'(iOut) != levelOf(mPhase, 0) || int'(qOut) != levelOf(mPhase, 1)) begin
      fails++;
      $display("FAIL R8 iq actual %0d,%0d expected %0d,%0d", iOut, qOut, levelOf(mPhase, 0), levelOf(mPhase, 1));
    end
    if (mSym == 1) begin
      checks++;
      if (lastSymPhase >= 0 && (phaseIdx[0] == lastSymPhase[0])) begin
        fails++;
        $display("FAIL R9 parity actual %0d expected odd/even flip from %0d", phaseIdx, lastSymPhase);
      end
      lastSymPhase = mPhase;
    end
  endtask

  // check current outputs, then drive next inputs and advance the model
  task automatic cyc(bit v, bit b, bit c);
    @(negedge clk);
    compare();
    clearIn = c; bitValid = v; bitIn = b;
    if (c) begin mPhase = 0; mPend = 0; mSym = 0; lastSymPhase = -1; end
    else if (v) begin
      if (mPend == 1) begin mPhase = (mPhase + incOf(mX, b) + 8) % 8; mSym = 1; mPend = 0; end
      else begin mX = b; mPend = 1; mSym = 0; end
    end else mSym = 0;
  endtask

  task automatic pair(bit x, bit y);
    cyc(1, x, 0); cyc(1, y, 0); cyc(0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tag = "R1"; cyc(0, 0, 0); cyc(0, 0, 0);
    tag = "R3"; pair(0, 0); pair(0, 1);
    tag = "R4"; pair(1, 0); pair(1, 1);
    tag = "R2"; for (int i = 0; i < 8; i++) cyc(1, i[1], 0);
    tag = "R5"; for (int i = 0; i < 6; i++) pair(0, 1);
    for (int i = 0; i < 6; i++) pair(1, 1);
    tag = "R6"; cyc(1, 1, 0); repeat (7) cyc(0, 1, 0); cyc(1, 0, 0); cyc(0, 0, 0);
    tag = "R7"; pair(0, 1); cyc(1, 1, 0); cyc(0, 0, 1); cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0);
    cyc(1, 1, 1); cyc(1, 0, 0); cyc(1, 1, 0); cyc(0, 0, 0);
    tag = "R2"; for (int i = 0; i < 600; i++) cyc(1'($urandom % 3 != 0), 1'($urandom), 1'($urandom % 41 == 0));
    cyc(0, 0, 0); cyc(0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule